// File: doc/BRIEF.md
# Burst-of-Two Double-Rate Static Memory

This block is a synthesizable behavioural model of a static memory that moves two data words for every command it accepts. It has a single input clock. The two clock phases are shown as a pair of buses, a rise bus and a fall bus, on each side. In each cycle the block samples an active-low load strobe, a read/write select and a word address. A write stores both words of the burst under per-byte, per-phase masks. A read returns both words a fixed, parameterised number of cycles later, together with a valid flag that acts as the echo / data-valid indication.

The lowest address bit sets the burst order, so either word of a burst can be addressed first. The data width is 18 or 36 bits, split into 9-bit byte lanes. The memory depth and the read latency are parameters. When no read data is being delivered, the data outputs are held at zero, which stands in for high impedance. A read already in flight always completes, even if the device is deselected right after it.

Top module: `ddr2b_sram`

## Requirements
- R1: When `ld_n` is 1 at a rising clock edge, no operation starts: the value of `rw` is ignored, the stored contents stay unchanged and no read data results.
- R2: When `ld_n` is 0 at a rising edge, `rw` = 1 starts a two-word read and `rw` = 0 starts a two-word write, both at the address sampled on that edge.
- R3: Let the pair base be the address with bit 0 cleared. With `addr[0]` = 0, the rise word goes to the base location and the fall word to base+1. With `addr[0]` = 1, the rise word goes to base+1 and the fall word to the base location. Reads use the same mapping: `rd_rise` returns the rise-position word and `rd_fall` the other.
- R4: The byte masks are active low and apply per phase: `bw_rise_n` qualifies `wdata_rise` and `bw_fall_n` qualifies `wdata_fall`. Mask bit i covers data bits 9i+8 down to 9i. There are DW/9 lanes. A lane whose mask bit is 1 keeps its stored value.
- R5: Read data appears on `rd_rise` and `rd_fall` exactly RD_LAT cycles after the accepting edge. `rd_valid` is 1 in that cycle only, once for each accepted read, including back-to-back reads.
- R6: Whenever `rd_valid` is 0, `rd_rise` and `rd_fall` are all zeros (the high-impedance stand-in). A read accepted just before `ld_n` goes high still delivers its data.
- R7: A read accepted in the cycle right after a write to the same address returns the merged result: unmasked bytes carry the new data and masked bytes carry the old values.
- R8: After reset, `rd_valid` is 0 and both read buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all commands are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read pipeline |
| ld_n | input | 1 | Active-low load strobe; low starts an operation |
| rw | input | 1 | 1 = read, 0 = write; used only when `ld_n` is low |
| addr | input | AW | Word address; bit 0 selects the burst order |
| wdata_rise | input | DW | Write word of the rising phase |
| wdata_fall | input | DW | Write word of the falling phase |
| bw_rise_n | input | DW/9 | Active-low byte mask for `wdata_rise` |
| bw_fall_n | input | DW/9 | Active-low byte mask for `wdata_fall` |
| rd_valid | output | 1 | Read data valid; also serves as output enable |
| rd_rise | output | DW | Read word of the rising phase, zero when not valid |
| rd_fall | output | DW | Read word of the falling phase, zero when not valid |

## Verification
The assertions assume that `ld_n` and `rw` are never unknown after reset. They also assume that every command is fully set up before the rising edge that samples it. The bench respects both by driving every input on the falling edge and holding it there for a full cycle. The bench first fills every location with full-mask writes, so no read can return an uninitialised word. It then mixes directed cases with seeded random commands whose masks, orders and read-after-write pairs stay inside the legal encodings.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;
   localparam int LANE_W = 9;

   typedef enum logic {
      OP_WRITE = 1'b0,
      OP_READ  = 1'b1
   } ddr_op_e;
endpackage

// File: rtl/ddr2b_bank.sv
module ddr2b_bank #(
   parameter int DW   = 36,
   parameter int ROWS = 32,
   localparam int NB  = DW / ddr2b_pkg::LANE_W,
   localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic          clk,
   input  logic          we,
   input  logic [RW-1:0] row,
   input  logic [DW-1:0] wd,
   input  logic [NB-1:0] be,
   output logic [DW-1:0] rd
);
   import ddr2b_pkg::*;

   logic [DW-1:0] mem [ROWS];

   always_ff @(posedge clk) begin
      if (we) begin
         for (int i = 0; i < NB; i++) begin
            if (be[i]) mem[row][i*LANE_W +: LANE_W] <= wd[i*LANE_W +: LANE_W];
         end
      end
   end

   // combinational read: a write committed on the previous edge is visible
   assign rd = mem[row];
endmodule

// File: rtl/ddr2b_order.sv
module ddr2b_order #(
   parameter int DW  = 36,
   localparam int NB = DW / ddr2b_pkg::LANE_W
) (
   input  logic          swap,
   input  logic [DW-1:0] wdata_rise,
   input  logic [DW-1:0] wdata_fall,
   input  logic [NB-1:0] bw_rise_n,
   input  logic [NB-1:0] bw_fall_n,
   output logic [DW-1:0] ev_wd,
   output logic [DW-1:0] od_wd,
   output logic [NB-1:0] ev_be,
   output logic [NB-1:0] od_be,
   input  logic [DW-1:0] ev_rd,
   input  logic [DW-1:0] od_rd,
   output logic [DW-1:0] rd_first,
   output logic [DW-1:0] rd_second
);
   always_comb begin
      if (swap) begin
         ev_wd     = wdata_fall;
         ev_be     = ~bw_fall_n;
         od_wd     = wdata_rise;
         od_be     = ~bw_rise_n;
         rd_first  = od_rd;
         rd_second = ev_rd;
      end else begin
         ev_wd     = wdata_rise;
         ev_be     = ~bw_rise_n;
         od_wd     = wdata_fall;
         od_be     = ~bw_fall_n;
         rd_first  = ev_rd;
         rd_second = od_rd;
      end
   end
endmodule

// File: rtl/ddr2b_rdpipe.sv
module ddr2b_rdpipe #(
   parameter int DW  = 36,
   parameter int LAT = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_v,
   input  logic [DW-1:0] in_rise,
   input  logic [DW-1:0] in_fall,
   output logic          out_v,
   output logic [DW-1:0] out_rise,
   output logic [DW-1:0] out_fall
);
   logic          v_q [LAT];
   logic [DW-1:0] r_q [LAT];
   logic [DW-1:0] f_q [LAT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < LAT; s++) begin
            v_q[s] <= 1'b0;
            r_q[s] <= '0;
            f_q[s] <= '0;
         end
      end else begin
         for (int s = LAT - 1; s > 0; s--) begin
            v_q[s] <= v_q[s-1];
            r_q[s] <= r_q[s-1];
            f_q[s] <= f_q[s-1];
         end
         v_q[0] <= in_v;
         r_q[0] <= in_v ? in_rise : '0;
         f_q[0] <= in_v ? in_fall : '0;
      end
   end

   assign out_v    = v_q[LAT-1];
   assign out_rise = r_q[LAT-1];
   assign out_fall = f_q[LAT-1];
endmodule

// File: rtl/ddr2b_sram.sv
module ddr2b_sram #(
   parameter int DW     = 36,
   parameter int AW     = 6,
   parameter int RD_LAT = 2,
   localparam int NB    = DW / ddr2b_pkg::LANE_W,
   localparam int ROWS  = 2 ** (AW - 1),
   localparam int RW    = AW - 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_n,
   input  logic          rw,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata_rise,
   input  logic [DW-1:0] wdata_fall,
   input  logic [NB-1:0] bw_rise_n,
   input  logic [NB-1:0] bw_fall_n,
   output logic          rd_valid,
   output logic [DW-1:0] rd_rise,
   output logic [DW-1:0] rd_fall
);
   import ddr2b_pkg::*;

   if (!(DW == 18 || DW == 36)) begin : g_bad_width
      $error("ddr2b_sram: DW must be 18 or 36");
   end
   if (AW < 2) begin : g_bad_addr
      $error("ddr2b_sram: AW must be at least 2");
   end
   if (RD_LAT < 1) begin : g_bad_lat
      $error("ddr2b_sram: RD_LAT must be at least 1");
   end

   logic          wr_go, rd_go;
   logic          ev_we, od_we;
   logic [DW-1:0] ev_wd, od_wd, ev_rd, od_rd, rd_first, rd_second;
   logic [NB-1:0] ev_be, od_be;
   logic [RW-1:0] row;

   assign wr_go = !ld_n && (ddr_op_e'(rw) == OP_WRITE);
   assign rd_go = !ld_n && (ddr_op_e'(rw) == OP_READ);
   assign ev_we = wr_go;
   assign od_we = wr_go;
   assign row   = addr[AW-1:1];

   ddr2b_order #(.DW(DW)) u_order (
      .swap       (addr[0]),
      .wdata_rise (wdata_rise),
      .wdata_fall (wdata_fall),
      .bw_rise_n  (bw_rise_n),
      .bw_fall_n  (bw_fall_n),
      .ev_wd      (ev_wd),
      .od_wd      (od_wd),
      .ev_be      (ev_be),
      .od_be      (od_be),
      .ev_rd      (ev_rd),
      .od_rd      (od_rd),
      .rd_first   (rd_first),
      .rd_second  (rd_second)
   );

   ddr2b_bank #(.DW(DW), .ROWS(ROWS)) u_even (
      .clk (clk), .we (ev_we), .row (row), .wd (ev_wd), .be (ev_be), .rd (ev_rd)
   );

   ddr2b_bank #(.DW(DW), .ROWS(ROWS)) u_odd (
      .clk (clk), .we (od_we), .row (row), .wd (od_wd), .be (od_be), .rd (od_rd)
   );

   ddr2b_rdpipe #(.DW(DW), .LAT(RD_LAT)) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_v     (rd_go),
      .in_rise  (rd_first),
      .in_fall  (rd_second),
      .out_v    (rd_valid),
      .out_rise (rd_rise),
      .out_fall (rd_fall)
   );
endmodule

// File: rtl/ddr2b_sram_chk.sv
module ddr2b_sram_chk #(
   parameter int DW     = 36,
   parameter int RD_LAT = 2,
   localparam int NB    = DW / ddr2b_pkg::LANE_W
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ld_n,
   input logic          rw,
   input logic          burst_bit,
   input logic [DW-1:0] wdata_rise,
   input logic [DW-1:0] wdata_fall,
   input logic [NB-1:0] bw_rise_n,
   input logic [NB-1:0] bw_fall_n,
   input logic          rd_valid,
   input logic [DW-1:0] rd_rise,
   input logic [DW-1:0] rd_fall,
   input logic          ev_we,
   input logic          od_we,
   input logic [DW-1:0] ev_wd,
   input logic [DW-1:0] od_wd,
   input logic [NB-1:0] ev_be,
   input logic [NB-1:0] od_be
);
   logic issued [RD_LAT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < RD_LAT; s++) issued[s] <= 1'b0;
      end else begin
         for (int s = RD_LAT - 1; s > 0; s--) issued[s] <= issued[s-1];
         issued[0] <= !ld_n && rw;
      end
   end

   assert_no_write_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ld_n |-> (!ev_we && !od_we));

   assert_write_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_n && !rw) |-> (ev_we && od_we));

   assert_read_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_n && rw) |-> (!ev_we && !od_we));

   assert_order_plain_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_n && !rw && !burst_bit) |->
         (ev_wd == wdata_rise && od_wd == wdata_fall && ev_be == ~bw_rise_n && od_be == ~bw_fall_n));

   assert_order_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_n && !rw && burst_bit) |->
         (ev_wd == wdata_fall && od_wd == wdata_rise && ev_be == ~bw_fall_n && od_be == ~bw_rise_n));

   assert_valid_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid == issued[RD_LAT-1]);

   assert_quiet_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_rise == '0 && rd_fall == '0));
endmodule

bind ddr2b_sram ddr2b_sram_chk #(.DW(DW), .RD_LAT(RD_LAT)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ld_n       (ld_n),
   .rw         (rw),
   .burst_bit  (addr[0]),
   .wdata_rise (wdata_rise),
   .wdata_fall (wdata_fall),
   .bw_rise_n  (bw_rise_n),
   .bw_fall_n  (bw_fall_n),
   .rd_valid   (rd_valid),
   .rd_rise    (rd_rise),
   .rd_fall    (rd_fall),
   .ev_we      (ev_we),
   .od_we      (od_we),
   .ev_wd      (ev_wd),
   .od_wd      (od_wd),
   .ev_be      (ev_be),
   .od_be      (od_be)
);

// File: tb/test_ddr2b_sram.sv
`timescale 1ns/100ps
module test_ddr2b_sram;
   localparam int DW     = 36;
   localparam int AW     = 6;
   localparam int RD_LAT = 2;
   localparam int NB     = DW / 9;
   localparam int DEPTH  = 2 ** AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_n = 1'b1;
   logic          rw = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata_rise = '0, wdata_fall = '0;
   logic [NB-1:0] bw_rise_n = '1, bw_fall_n = '1;
   logic          rd_valid;
   logic [DW-1:0] rd_rise, rd_fall;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [DW-1:0] ref_mem [DEPTH];
   logic          ex_v [RD_LAT];
   logic [DW-1:0] ex_r [RD_LAT];
   logic [DW-1:0] ex_f [RD_LAT];
   string         ex_t [RD_LAT];

   always #2.5 clk = ~clk;

   ddr2b_sram #(.DW(DW), .AW(AW), .RD_LAT(RD_LAT)) i_ddr2b_sram (
      .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
      .wdata_rise(wdata_rise), .wdata_fall(wdata_fall),
      .bw_rise_n(bw_rise_n), .bw_fall_n(bw_fall_n),
      .rd_valid(rd_valid), .rd_rise(rd_rise), .rd_fall(rd_fall)
   );

   function automatic logic [DW-1:0] merge(logic [DW-1:0] old_w, logic [DW-1:0] new_w,
                                           logic [NB-1:0] mask_n);
      logic [DW-1:0] r = old_w;
      for (int i = 0; i < NB; i++) if (!mask_n[i]) r[i*9 +: 9] = new_w[i*9 +: 9];
      return r;
   endfunction

   function automatic logic [DW-1:0] rnd_word();
      return {$urandom(), $urandom()};
   endfunction

   task automatic check_out(string tag);
      string t = ex_v[RD_LAT-1] ? ex_t[RD_LAT-1] : tag;
      checks++;
      if (rd_valid !== ex_v[RD_LAT-1] || rd_rise !== ex_r[RD_LAT-1] || rd_fall !== ex_f[RD_LAT-1]) begin
         fails++;
         $display("FAIL %s: valid/rise/fall got %0b/%h/%h expected %0b/%h/%h", t,
                  rd_valid, rd_rise, rd_fall, ex_v[RD_LAT-1], ex_r[RD_LAT-1], ex_f[RD_LAT-1]);
      end
   endtask

   // one command cycle: drive, model the edge, check at the falling edge
   task automatic cyc(bit l_n, bit r, logic [AW-1:0] a, logic [DW-1:0] wr, logic [DW-1:0] wf,
                      logic [NB-1:0] br, logic [NB-1:0] bf, string tag);
      logic [AW-1:0] first, second;
      ld_n = l_n; rw = r; addr = a; wdata_rise = wr; wdata_fall = wf;
      bw_rise_n = br; bw_fall_n = bf;
      first  = a;
      second = {a[AW-1:1], ~a[0]};
      @(posedge clk);
      for (int s = RD_LAT - 1; s > 0; s--) begin
         ex_v[s] = ex_v[s-1]; ex_r[s] = ex_r[s-1]; ex_f[s] = ex_f[s-1]; ex_t[s] = ex_t[s-1];
      end
      ex_v[0] = 1'b0; ex_r[0] = '0; ex_f[0] = '0; ex_t[0] = tag;
      if (!l_n && r) begin
         ex_v[0] = 1'b1; ex_r[0] = ref_mem[first]; ex_f[0] = ref_mem[second];
      end else if (!l_n) begin
         ref_mem[first]  = merge(ref_mem[first], wr, br);
         ref_mem[second] = merge(ref_mem[second], wf, bf);
      end
      @(negedge clk);
      check_out(l_n ? "R6" : tag);
   endtask

   task automatic idle(int n, bit r);
      for (int i = 0; i < n; i++) cyc(1'b1, r, '0, rnd_word(), rnd_word(), '0, '0, "R1");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [DW-1:0] a_r, a_f;
      int seed;
      seed = $urandom(32'h5EED_0D0E);
      for (int s = 0; s < RD_LAT; s++) begin
         ex_v[s] = 1'b0; ex_r[s] = '0; ex_f[s] = '0; ex_t[s] = "R8";
      end
      repeat (3) @(negedge clk);
      check_out("R8");            // R8 reset state
      rst_n = 1'b1;

      // fill the array with full-mask writes
      for (int a = 0; a < DEPTH; a += 2)
         cyc(1'b0, 1'b0, a[AW-1:0], rnd_word(), rnd_word(), '0, '0, "R2");

      // R2 / R3: both orders on write and read
      a_r = 36'h1_2345_6789; a_f = 36'h9_8765_4321;
      cyc(1'b0, 1'b0, 6'd4, a_r, a_f, '0, '0, "R3");
      cyc(1'b0, 1'b1, 6'd4, '0, '0, '1, '1, "R3");
      cyc(1'b0, 1'b1, 6'd5, '0, '0, '1, '1, "R3");
      cyc(1'b0, 1'b0, 6'd11, a_r, a_f, '0, '0, "R3");
      cyc(1'b0, 1'b1, 6'd10, '0, '0, '1, '1, "R3");
      idle(RD_LAT, 1'b1);

      // R4: per-phase partial masks
      cyc(1'b0, 1'b0, 6'd6, '1, '0, 4'b1010, 4'b0110, "R4");
      cyc(1'b0, 1'b0, 6'd7, 36'hA_AAAA_AAAA, 36'h5_5555_5555, 4'b1110, 4'b0111, "R4");
      cyc(1'b0, 1'b1, 6'd6, '0, '0, '1, '1, "R4");
      idle(RD_LAT, 1'b0);

      // R1: strobe high with rw low and live data must not write
      cyc(1'b1, 1'b0, 6'd12, '1, '1, '0, '0, "R1");
      cyc(1'b1, 1'b1, 6'd12, '0, '0, '0, '0, "R1");
      cyc(1'b0, 1'b1, 6'd12, '0, '0, '1, '1, "R1");
      idle(RD_LAT, 1'b1);

      // R7: read right after a masked write, both orders
      cyc(1'b0, 1'b0, 6'd8, rnd_word(), rnd_word(), 4'b0101, 4'b1001, "R7");
      cyc(1'b0, 1'b1, 6'd8, '0, '0, '1, '1, "R7");
      cyc(1'b0, 1'b0, 6'd9, rnd_word(), rnd_word(), 4'b0011, 4'b1100, "R7");
      cyc(1'b0, 1'b1, 6'd9, '0, '0, '1, '1, "R7");

      // R6: deselect right after a read; data still arrives, then the bus is quiet
      cyc(1'b0, 1'b1, 6'd20, '0, '0, '1, '1, "R6");
      idle(RD_LAT + 2, 1'b1);

      // R5: back-to-back reads
      for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, i[AW-1:0], '0, '0, '1, '1, "R5");
      idle(RD_LAT, 1'b0);

      // constrained random traffic
      for (int i = 0; i < 3000; i++) begin
         bit l_n = ($urandom_range(0, 3) == 0);
         cyc(l_n, $urandom_range(0, 1) == 1, $urandom_range(0, DEPTH - 1), rnd_word(), rnd_word(),
             $urandom_range(0, 15), $urandom_range(0, 15), "R5");
      end
      idle(RD_LAT, 1'b0);
      finish_run();
   end
endmodule